// File: doc/BRIEF.md
# Timer-Stamping Input Capture Channel

This block records when edges arrive on an asynchronous input pin. The pin is first re-timed to the system clock by a two-flop synchroniser and then compared with a history flop to find rising and falling edges. A 3-bit mode field selects which edges count, and optionally divides rising edges by four or sixteen. Each qualified event stores the current value of one of two external 16-bit free-running timers into a four-entry FIFO. Software reads the FIFO one entry per read strobe.

Two status outputs report the FIFO state: one says at least one entry is waiting, the other says a capture was lost. An interrupt output pulses for one cycle after a programmable number of captures. Differences between consecutive stamps give the period, the frequency or the pulse width of the input.

Top module: `tstamp_capture`

## Requirements
- R1: A level change on `pin_i` that follows a quiet pin is stored three clock edges later. The stored value is the timer value present in the cycle before that third edge.
- R2: `tsel_i` = 0 stores `timer_a_i` and `tsel_i` = 1 stores `timer_b_i`.
- R3: The capturing modes use these codes. 3'b001 captures on every edge, 3'b010 on falling edges only and 3'b011 on rising edges only.
- R4: Code 3'b100 captures on every 4th rising edge and code 3'b101 on every 16th rising edge. Rising edges are counted from the last time the channel was off.
- R5: Codes 3'b000, 3'b110 and 3'b111 turn the channel off. No capture is made, the FIFO is emptied, overflow is cleared, and the prescaler and interrupt counts return to zero.
- R6: After reset the FIFO is empty, overflow and interrupt are low and `rdata_o` is 0. Up to 4 stamps are held and read out in arrival order.
- R7: A capture that arrives while the FIFO holds 4 entries and no read is made is discarded and sets `ovf_o`. `ovf_o` stays high until a read empties the FIFO or the channel is turned off.
- R8: A capture and a read in the same cycle with a full FIFO are both honoured. The head is read out, the new stamp is stored and overflow is not set.
- R9: With `icnt_i` = n, `irq_o` is high for one cycle on every (n+1)th qualified event, counting discarded events too. It rises in the same cycle as the FIFO status for that capture.
- R10: A read of an empty FIFO leaves `rdata_o` at the last value read and changes no status.
- R11: A read updates `rdata_o` on the next clock edge. `nempty_o` is low right after the read that removes the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture pin |
| mode_i | input | 3 | Edge and prescale mode, codes per R3 to R5 |
| tsel_i | input | 1 | Timebase select: 0 = timer A, 1 = timer B |
| icnt_i | input | 2 | Interrupt after icnt_i+1 captures |
| timer_a_i | input | 16 | Free-running count of timer A |
| timer_b_i | input | 16 | Free-running count of timer B |
| rd_i | input | 1 | FIFO read strobe |
| rdata_o | output | 16 | Last stamp read from the FIFO |
| nempty_o | output | 1 | FIFO holds at least one stamp |
| ovf_o | output | 1 | A capture was lost to a full FIFO |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A capture write and a read strobe can fall on the same clock edge. The bench provokes this by raising the read strobe exactly in the cycle before a pin change reaches the FIFO. It does so with the FIFO empty, partly filled and full. For each case it checks that the old head appears on the read port, that the new stamp survives for a later read, and that overflow stays low when the FIFO was full. The same timing is also used to confirm that an empty-FIFO read beside a capture keeps the previous read value.

// File: rtl/cap_pkg.sv
package cap_pkg;
   localparam logic [2:0] MODE_OFF      = 3'b000;
   localparam logic [2:0] MODE_ANY      = 3'b001;
   localparam logic [2:0] MODE_FALL     = 3'b010;
   localparam logic [2:0] MODE_RISE     = 3'b011;
   localparam logic [2:0] MODE_RISE_D4  = 3'b100;
   localparam logic [2:0] MODE_RISE_D16 = 3'b101;

   function automatic logic mode_is_on(input logic [2:0] m);
      return (m != MODE_OFF) && (m <= MODE_RISE_D16);
   endfunction
endpackage

// File: rtl/cap_edge_sync.sv
module cap_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic rise_o,
   output logic fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("cap_edge_sync: STAGES must be at least 2");
   end

   // chain[STAGES-1:0] re-time the pin, chain[STAGES] holds the previous level
   logic [STAGES:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-1:0], pin_i};
   end

   assign rise_o =  chain[STAGES-1] & ~chain[STAGES];
   assign fall_o = ~chain[STAGES-1] &  chain[STAGES];

   assert_rise_tracks_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |-> $past(pin_i, STAGES));
   assert_fall_tracks_pin_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fall_o |-> !$past(pin_i, STAGES));
endmodule

// File: rtl/cap_qualify.sv
module cap_qualify
   import cap_pkg::*;
#(
   parameter int DIV_MID = 4,
   parameter int DIV_HI  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] mode_i,
   input  logic       rise_i,
   input  logic       fall_i,
   output logic       evt_o
);
   localparam int PW = $clog2(DIV_HI);

   if (DIV_MID < 2 || DIV_MID >= DIV_HI) begin : g_bad_div
      $error("cap_qualify: need 2 <= DIV_MID < DIV_HI");
   end

   logic          active;
   logic          sel_edge;
   logic          div_on;
   logic [PW-1:0] limit;
   logic [PW-1:0] pcnt;
   logic          at_limit;

   assign active = mode_is_on(mode_i);

   always_comb begin
      sel_edge = 1'b0;
      div_on   = 1'b0;
      limit    = '0;
      case (mode_i)
         MODE_ANY:  sel_edge = rise_i | fall_i;
         MODE_FALL: sel_edge = fall_i;
         MODE_RISE: sel_edge = rise_i;
         MODE_RISE_D4: begin
            sel_edge = rise_i;
            div_on   = 1'b1;
            limit    = PW'(DIV_MID - 1);
         end
         MODE_RISE_D16: begin
            sel_edge = rise_i;
            div_on   = 1'b1;
            limit    = PW'(DIV_HI - 1);
         end
         default: ;
      endcase
   end

   // a count left above the limit by a mode switch wraps on the next edge
   assign at_limit = (pcnt >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pcnt <= '0;
      else if (!active)          pcnt <= '0;
      else if (sel_edge && div_on) begin
         if (at_limit) pcnt <= '0;
         else          pcnt <= pcnt + 1'b1;
      end
   end

   assign evt_o = sel_edge && (!div_on || at_limit);

   assert_no_event_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o |-> mode_is_on(mode_i));
   assert_prescale_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_is_on(mode_i) |=> (pcnt == '0));
endmodule

// File: rtl/cap_fifo.sv
module cap_fifo #(
   parameter int W     = 16,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         flush_i,
   input  logic         push_i,
   input  logic [W-1:0] wdata_i,
   input  logic         pop_i,
   output logic [W-1:0] rdata_o,
   output logic         nempty_o,
   output logic         ovf_o
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] CNT_FULL = (AW + 1)'(DEPTH);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("cap_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;
   logic [AW:0]   cnt;
   logic          pop_ok, push_ok, drop;

   assign pop_ok  = pop_i && (cnt != '0);
   assign push_ok = push_i && ((cnt != CNT_FULL) || pop_ok);
   assign drop    = push_i && !push_ok;

   always_ff @(posedge clk) begin
      if (push_ok && !flush_i) mem[wp] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp      <= '0;
         rp      <= '0;
         cnt     <= '0;
         rdata_o <= '0;
         ovf_o   <= 1'b0;
      end else if (flush_i) begin
         wp    <= '0;
         rp    <= '0;
         cnt   <= '0;
         ovf_o <= 1'b0;
      end else begin
         if (pop_ok) begin
            rdata_o <= mem[rp];
            rp      <= rp + 1'b1;
         end
         if (push_ok) wp <= wp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: ;
         endcase
         if (drop)                                   ovf_o <= 1'b1;
         else if (pop_ok && !push_ok && cnt == 1)    ovf_o <= 1'b0;
      end
   end

   assign nempty_o = (cnt != '0);

   assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);
   assert_ovf_only_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> $past(cnt == CNT_FULL && push_i && !pop_i));
   assert_full_swap_keeps_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_FULL && push_i && pop_i && !flush_i) |=> (cnt == CNT_FULL) && $stable(ovf_o));
   assert_empty_read_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && cnt == '0 && !flush_i) |=> $stable(rdata_o));
   assert_last_pop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && cnt == 1 && !flush_i) |=> !nempty_o);
endmodule

// File: rtl/cap_irq_count.sv
module cap_irq_count #(
   parameter int CW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear_i,
   input  logic          evt_i,
   input  logic [CW-1:0] thresh_i,
   output logic          irq_o
);
   if (CW < 1) begin : g_bad_cw
      $error("cap_irq_count: CW must be at least 1");
   end

   logic [CW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen  <= '0;
         irq_o <= 1'b0;
      end else if (clear_i) begin
         seen  <= '0;
         irq_o <= 1'b0;
      end else begin
         irq_o <= 1'b0;
         if (evt_i) begin
            if (seen >= thresh_i) begin
               seen  <= '0;
               irq_o <= 1'b1;
            end else begin
               seen <= seen + 1'b1;
            end
         end
      end
   end

   assert_irq_follows_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(evt_i && !clear_i));
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture
   import cap_pkg::*;
#(
   parameter int TW          = 16,
   parameter int DEPTH       = 4,
   parameter int SYNC_STAGES = 2,
   parameter int DIV_MID     = 4,
   parameter int DIV_HI      = 16,
   parameter int ICW         = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           pin_i,
   input  logic [2:0]     mode_i,
   input  logic           tsel_i,
   input  logic [ICW-1:0] icnt_i,
   input  logic [TW-1:0]  timer_a_i,
   input  logic [TW-1:0]  timer_b_i,
   input  logic           rd_i,
   output logic [TW-1:0]  rdata_o,
   output logic           nempty_o,
   output logic           ovf_o,
   output logic           irq_o
);
   if (TW < 1) begin : g_bad_tw
      $error("tstamp_capture: TW must be at least 1");
   end

   logic          rise, fall, evt, off;
   logic [TW-1:0] stamp;

   assign off   = !mode_is_on(mode_i);
   assign stamp = tsel_i ? timer_b_i : timer_a_i;

   cap_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .rise_o(rise), .fall_o(fall));

   cap_qualify #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI)) u_qual (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .rise_i(rise), .fall_i(fall), .evt_o(evt));

   cap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush_i(off), .push_i(evt), .wdata_i(stamp),
      .pop_i(rd_i), .rdata_o(rdata_o), .nempty_o(nempty_o), .ovf_o(ovf_o));

   cap_irq_count #(.CW(ICW)) u_irq (
      .clk(clk), .rst_n(rst_n), .clear_i(off), .evt_i(evt),
      .thresh_i(icnt_i), .irq_o(irq_o));

   assert_off_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      off |=> !nempty_o && !ovf_o && !irq_o);
   assert_capture_sets_nempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt && !off) |=> nempty_o);
endmodule

// File: tb/tstamp_capture_bench.sv
module tstamp_capture_bench;
   import cap_pkg::*;
   localparam int DEPTH = 4;

   logic        clk = 1'b0, rst_n = 1'b0, pin = 1'b0, tsel = 1'b0, rd = 1'b0;
   logic [2:0]  mode = 3'b000;
   logic [1:0]  icnt = 2'd0;
   logic [15:0] ta = 16'h1230;
   logic [15:0] tb;
   logic [15:0] rdata;
   logic        nempty, ovf, irq;

   int nchk = 0, nerr = 0;

   logic [15:0] mq [DEPTH];
   int          mcnt = 0, pdiv = 0, ic = 0;
   bit          movf = 0;
   logic [15:0] mlast = 16'h0;
   logic        lvl = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) ta <= ta + 16'd1;
   assign tb = 16'(ta * 16'd5 + 16'h0101);

   tstamp_capture u_tstamp_capture (
      .clk(clk), .rst_n(rst_n), .pin_i(pin), .mode_i(mode), .tsel_i(tsel),
      .icnt_i(icnt), .timer_a_i(ta), .timer_b_i(tb), .rd_i(rd),
      .rdata_o(rdata), .nempty_o(nempty), .ovf_o(ovf), .irq_o(irq));

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_pop(output logic [15:0] v, output bit ok);
      ok = (mcnt > 0);
      if (ok) begin
         v = mq[0];
         for (int i = 0; i < DEPTH - 1; i++) mq[i] = mq[i + 1];
         mcnt--;
         mlast = v;
      end else v = mlast;
   endtask

   task automatic set_mode(input logic [2:0] m);
      @(negedge clk);
      mode = m;
      if (!mode_is_on(m)) begin
         mcnt = 0; movf = 0; pdiv = 0; ic = 0;
      end
      @(negedge clk);
      chk("R5", "nempty after mode write", 32'(nempty), 32'(mcnt != 0));
      chk("R5", "ovf after mode write", 32'(ovf), 32'(movf));
   endtask

   task automatic toggle(input bit with_read, input string tag);
      logic [15:0] stamp, v;
      bit rise, fall, q, popped, pushed, exirq;
      @(negedge clk);
      stamp = 16'(ta + 16'd2);
      if (tsel) stamp = 16'(stamp * 16'd5 + 16'h0101);
      pin = ~pin;
      @(negedge clk);
      @(negedge clk);
      if (with_read) rd = 1'b1;
      @(negedge clk);
      rd = 1'b0;
      popped = 0;
      v = mlast;
      if (with_read) model_pop(v, popped);
      rise = pin && !lvl;
      fall = !pin && lvl;
      lvl  = pin;
      q = 0;
      case (mode)
         3'b001: q = 1;
         3'b010: q = fall;
         3'b011: q = rise;
         3'b100: if (rise) begin if (pdiv >= 3) begin q = 1; pdiv = 0; end else pdiv++; end
         3'b101: if (rise) begin if (pdiv >= 15) begin q = 1; pdiv = 0; end else pdiv++; end
         default: q = 0;
      endcase
      pushed = 0;
      exirq  = 0;
      if (q) begin
         if (mcnt < DEPTH) begin mq[mcnt] = stamp; mcnt++; pushed = 1; end
         else movf = 1;
         exirq = (ic >= int'(icnt));
         ic = exirq ? 0 : ic + 1;
      end
      if (popped && !pushed && mcnt == 0) movf = 0;
      chk("R9", "irq pulse", 32'(irq), 32'(exirq));
      chk(tag, "nempty after edge", 32'(nempty), 32'(mcnt != 0));
      chk(tag, "ovf after edge", 32'(ovf), 32'(movf));
      if (with_read) chk(tag, "rdata with same-cycle capture", 32'(rdata), 32'(v));
      @(negedge clk);
      chk("R9", "irq one cycle", 32'(irq), 32'd0);
   endtask

   task automatic do_read(input string tag);
      logic [15:0] v;
      bit ok;
      @(negedge clk); rd = 1'b1;
      @(negedge clk); rd = 1'b0;
      model_pop(v, ok);
      if (ok && mcnt == 0) movf = 0;
      chk(ok ? tag : "R10", "rdata", 32'(rdata), 32'(v));
      chk("R11", "nempty after read", 32'(nempty), 32'(mcnt != 0));
      chk(ok ? "R7" : "R10", "ovf after read", 32'(ovf), 32'(movf));
   endtask

   initial begin
      #800000;
      nerr++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R6", "reset rdata", 32'(rdata), 32'd0);
      chk("R6", "reset nempty", 32'(nempty), 32'd0);
      chk("R6", "reset ovf", 32'(ovf), 32'd0);
      chk("R6", "reset irq", 32'(irq), 32'd0);
      rst_n = 1'b1;

      set_mode(3'b011);
      toggle(0, "R3"); toggle(0, "R3");
      do_read("R1"); do_read("R10");
      set_mode(3'b010);
      toggle(0, "R3"); toggle(0, "R3");
      do_read("R3"); do_read("R10");
      set_mode(3'b001);
      toggle(0, "R3"); tsel = 1'b1; toggle(0, "R3");
      do_read("R2"); do_read("R2");

      for (int n = 0; n < 4; n++) begin
         set_mode(3'b000);
         icnt = 2'(n);
         set_mode(3'b001);
         for (int k = 0; k < 8; k++) begin
            tsel = k[0];
            toggle(0, "R2");
            do_read("R2");
         end
      end

      icnt = 2'd0; tsel = 1'b0;
      set_mode(3'b000); set_mode(3'b100);
      for (int k = 0; k < 16; k++) begin
         toggle(0, "R4");
         if (k % 4 == 3) do_read("R4");
      end
      set_mode(3'b000); set_mode(3'b101);
      for (int k = 0; k < 34; k++) begin
         toggle(0, "R4");
         if (k % 8 == 7) do_read("R4");
      end
      do_read("R4"); do_read("R4");

      set_mode(3'b000); set_mode(3'b001); icnt = 2'd3;
      for (int k = 0; k < 6; k++) toggle(0, "R7");
      for (int k = 0; k < 5; k++) do_read("R7");

      set_mode(3'b000); set_mode(3'b001); icnt = 2'd1; tsel = 1'b1;
      toggle(1, "R10");
      for (int k = 0; k < 4; k++) toggle(0, "R6");
      for (int k = 0; k < 3; k++) toggle(1, "R8");
      toggle(0, "R7");
      for (int k = 0; k < 5; k++) do_read("R8");

      set_mode(3'b000); set_mode(3'b001);
      toggle(0, "R5"); toggle(0, "R5");
      set_mode(3'b110);
      toggle(0, "R5"); toggle(0, "R5");
      set_mode(3'b111);
      toggle(0, "R5");
      set_mode(3'b000);
      toggle(0, "R5");
      do_read("R10");

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule